// File: doc/BRIEF.md
# Two-Level Register Access Bridge with MDIO Management Master

This block lets a host reach two tiers of registers through a pair of host-visible words. The host first loads a 32-bit data word, then writes a command word that holds a target index, a direction bit and a busy bit. The bridge moves the data word into the selected internal register, or loads the selected register into the data word. The busy bit reads 1 until the move is finished.

Two of the internal registers form a second access pair for PHY management. When a management access word with its own busy bit set is written, a complete serial management frame is sent on the MDC/MDIO pins. A write frame sends the management data word to the addressed PHY register. A read frame returns the PHY register into the management data word. The direction bit has the opposite sense at each tier. At the command tier a 1 means read. At the management tier a 1 means write.

The internal PHY answers at address 1. External PHYs are expected to avoid addresses 0, 1 and 31. The bridge does not check PHY addresses.

Top module: `csr_mii_bridge`

## Requirements
- R1: After reset, the command word and the data word read 0, mdc and mdio_oe are low, and cmd_err is low.
- R2: The command word has busy in bit 31, direction in bit 30 (1 = register into data word, 0 = data word into register) and the register index in bits 7:0. All other bits read 0. Host select 0 addresses the command word and select 1 addresses the data word.
- R3: A single host write may set index, direction and busy together. Busy then reads 1 in the cycle after that write and 0 one cycle later, when the transfer has completed.
- R4: Indices 0 to 5 are plain 32-bit storage. An index at or above the bank size reads as 0, and writes to it are discarded.
- R5: A host write made while the command busy bit is 1 is ignored. A command-tier write command to index 6 or 7 made while the management busy bit is 1 is also ignored. Each ignored write raises cmd_err for one cycle in the cycle after the write.
- R6: Index 6 is the management access word. It holds the PHY address in bits 15:11, the PHY register in bits 10:6, direction in bit 1 (1 = write to PHY) and busy in bit 0. Its other bits read 0. Writing it with bit 0 clear stores the fields and starts no frame. Index 7 holds a 16-bit management data word, and its upper half reads 0.
- R7: Writing index 6 with bit 0 set starts a frame. Bit 0 of index 6 reads 1 until the frame ends, and the stored fields read back unchanged afterwards.
- R8: A write frame is 64 MDC bits, all driven. The bits are 32 ones, 01, opcode 01, PHY address, register, turnaround 10, then the data word with the MSB first.
- R9: A read frame uses opcode 10. MDIO is released (mdio_oe low) for frame bits 46 to 63. Bits 48 to 63 are sampled on MDC rising edges, MSB first, into index 7.
- R10: MDC is low while idle. During a frame its period is 2*MDC_HALF clock cycles, with 64 rising edges per frame. mdio_out and mdio_oe change only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = command word, 1 = data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected host word (combinational) |
| cmd_err | output | 1 | One-cycle pulse when a host write is ignored |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for mdio_out |
| mdio_in | input | 1 | Management data from the PHY |

## Verification
The command tier is driven with a table of index and data pairs. The table covers plain storage, an out-of-range index, the 16-bit management data word and the management access word written without busy. Between them, these entries separate the storage path, index decode, field masking and a spurious frame launch. A write frame and a read frame, with different PHY addresses, register indices and data, are captured bit by bit by a PHY model. The captures show opcode and turnaround differences, bus release and bit order. Rejected writes are tried both while the command tier is busy and while a frame runs, so the two blocking sources are checked separately.

// File: rtl/csr_mii_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and frame builder for the two-level access bridge.
package csr_mii_pkg;
    localparam logic [7:0] MGMT_ACC_IDX = 8'd6;
    localparam logic [7:0] MGMT_DAT_IDX = 8'd7;
    localparam int FRAME_BITS  = 64;
    localparam int HDR_BITS    = 46;
    localparam int DATA_FIRST  = 48;

    typedef struct packed {
        logic       busy;
        logic       rnw;
        logic [7:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regi;
        logic       wr;
    } mgmt_t;

    // Assemble the full serial frame, first bit in position 63.
    function automatic logic [63:0] build_frame(input mgmt_t m, input logic [15:0] d);
        logic [1:0] op;
        logic [1:0] ta;
        op = m.wr ? 2'b01 : 2'b10;
        ta = m.wr ? 2'b10 : 2'b00;
        return {32'hFFFF_FFFF, 2'b01, op, m.phy, m.regi, ta, (m.wr ? d : 16'h0000)};
    endfunction
endpackage

// File: rtl/csr_host_port.sv
`timescale 1ns/1ps
// Host-facing command and data words.
// Holds the command word and the data word, decides when a host write is refused,
// and completes each command-tier transfer one cycle after it is issued.
// Assumes the register bank answers reads combinationally.
module csr_host_port
    import csr_mii_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    input  logic        mgmt_busy,
    input  logic [31:0] bank_rdata,
    output logic [31:0] host_rdata,
    output logic        cmd_busy,
    output logic        cmd_rnw,
    output logic [7:0]  cmd_addr,
    output logic [31:0] data_word,
    output logic        cmd_err
);
    cmd_t        cmd_q;
    logic [31:0] data_q;
    logic        err_q;
    logic        hits_mgmt;
    logic        blocked;

    // Detect a write command aimed at the management pair.
    always_comb begin
        hits_mgmt = !host_sel && host_wdata[31] && !host_wdata[30] &&
                    ((host_wdata[7:0] == MGMT_ACC_IDX) || (host_wdata[7:0] == MGMT_DAT_IDX));
        blocked   = cmd_q.busy || (mgmt_busy && hits_mgmt);
    end

    // Update the command and data words and raise the refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= host_wr && blocked;
            if (cmd_q.busy) begin
                cmd_q.busy <= 1'b0;
                if (cmd_q.rnw) data_q <= bank_rdata;
            end
            if (host_wr && !blocked) begin
                if (!host_sel) cmd_q <= '{busy: host_wdata[31], rnw: host_wdata[30], addr: host_wdata[7:0]};
                else           data_q <= host_wdata;
            end
        end
    end

    // Present the selected host word.
    always_comb begin
        host_rdata = host_sel ? data_q : {cmd_q.busy, cmd_q.rnw, 22'b0, cmd_q.addr};
    end

    assign cmd_busy  = cmd_q.busy;
    assign cmd_rnw   = cmd_q.rnw;
    assign cmd_addr  = cmd_q.addr;
    assign data_word = data_q;
    assign cmd_err   = err_q;
endmodule

// File: rtl/csr_reg_bank.sv
`timescale 1ns/1ps
// Internal register bank.
// Indices 6 and 7 form the management pair. Every other index is plain 32-bit storage.
// Writes to index 6 with bit 0 set request a frame. Read results from the master land in index 7.
// Assumes NREG is at least 8 and a power of two.
module csr_reg_bank
    import csr_mii_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_en,
    input  logic        xfer_rnw,
    input  logic [7:0]  xfer_addr,
    input  logic [31:0] xfer_wdata,
    input  logic        mgmt_busy,
    input  logic        mgmt_done_rd,
    input  logic [15:0] mgmt_rdata,
    output logic [31:0] rdata,
    output logic        mgmt_start,
    output mgmt_t       start_cfg,
    output logic [15:0] mgmt_wdata
);
    localparam int         IDX_W  = $clog2(NREG);
    localparam logic [7:0] NREG_L = 8'(NREG);

    logic        in_range;
    logic        wr_en;
    logic [31:0] rd_word [NREG];
    mgmt_t       acc_q;
    logic [15:0] dat_q;

    assign in_range   = xfer_addr < NREG_L;
    assign wr_en      = xfer_en && !xfer_rnw && in_range;
    assign mgmt_start = wr_en && (xfer_addr == MGMT_ACC_IDX) && xfer_wdata[0];
    assign start_cfg  = '{phy: xfer_wdata[15:11], regi: xfer_wdata[10:6], wr: xfer_wdata[1]};
    assign mgmt_wdata = dat_q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == int'(MGMT_ACC_IDX)) begin : g_acc
            // Hold the management access fields.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      acc_q <= '0;
                else if (wr_en && xfer_addr == MGMT_ACC_IDX) acc_q <= start_cfg;
            end
            assign rd_word[i] = {16'b0, acc_q.phy, acc_q.regi, 4'b0, acc_q.wr, mgmt_busy};
        end else if (i == int'(MGMT_DAT_IDX)) begin : g_dat
            // Hold the management data word, loaded by the host or by a finished read frame.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      dat_q <= '0;
                else if (wr_en && xfer_addr == MGMT_DAT_IDX) dat_q <= xfer_wdata[15:0];
                else if (mgmt_done_rd)                           dat_q <= mgmt_rdata;
            end
            assign rd_word[i] = {16'b0, dat_q};
        end else begin : g_plain
            logic [31:0] store_q;
            // Plain storage register.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 store_q <= '0;
                else if (wr_en && xfer_addr == 8'(i)) store_q <= xfer_wdata;
            end
            assign rd_word[i] = store_q;
        end
    end

    // Select the addressed register, or zero when the index is out of range.
    always_comb begin
        rdata = in_range ? rd_word[xfer_addr[IDX_W-1:0]] : 32'h0;
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Serial management frame engine.
// Divides clk into MDC, shifts out a 64-bit frame with changes while MDC is low,
// releases MDIO for read turnaround and read data, and samples on MDC rising edges.
// Assumes start is only asserted while idle.
module mdio_master
    import csr_mii_pkg::*;
#(
    parameter int MDC_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mgmt_t       start_cfg,
    input  logic [15:0] wdata,
    input  logic        mdio_in,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        done_rd,
    output logic [15:0] rdata
);
    localparam int         CNT_W    = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
    localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);

    logic        busy_q, mdc_q, is_wr_q;
    logic [5:0]  bit_q;
    logic [63:0] frame_q;
    logic [15:0] rd_q;
    logic        tick, rise, fall, last;

    if (MDC_HALF == 1) begin : g_nodiv
        assign tick = busy_q;
    end else begin : g_div
        logic [CNT_W-1:0] div_q;
        // Count clk cycles within each MDC half period.
        always_ff @(posedge clk) begin
            if (!rst_n)                 div_q <= '0;
            else if (!busy_q || tick)   div_q <= '0;
            else                        div_q <= div_q + 1'b1;
        end
        assign tick = busy_q && (div_q == CNT_W'(MDC_HALF - 1));
    end

    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign last = bit_q == LAST_BIT;

    // Sequence the frame: load, toggle MDC, sample and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            mdc_q   <= 1'b0;
            is_wr_q <= 1'b0;
            bit_q   <= '0;
            frame_q <= '0;
            rd_q    <= '0;
        end else if (start && !busy_q) begin
            busy_q  <= 1'b1;
            mdc_q   <= 1'b0;
            is_wr_q <= start_cfg.wr;
            bit_q   <= '0;
            frame_q <= build_frame(start_cfg, wdata);
            rd_q    <= '0;
        end else if (busy_q) begin
            if (rise) begin
                mdc_q <= 1'b1;
                if (!is_wr_q && bit_q >= 6'(DATA_FIRST)) rd_q <= {rd_q[14:0], mdio_in};
            end
            if (fall) begin
                mdc_q <= 1'b0;
                if (last) busy_q <= 1'b0;
                else      bit_q  <= bit_q + 1'b1;
            end
        end
    end

    assign busy     = busy_q;
    assign mdc      = mdc_q;
    assign mdio_out = busy_q && frame_q[LAST_BIT - bit_q];
    assign mdio_oe  = busy_q && (is_wr_q || bit_q < 6'(HDR_BITS));
    assign done_rd  = fall && last && !is_wr_q;
    assign rdata    = rd_q;
endmodule

// File: rtl/csr_mii_bridge.sv
`timescale 1ns/1ps
// Top level of the two-level register access bridge.
// Connects the host words, the internal bank and the management frame engine.
// Assumes a single host master and a PHY that drives read data while MDIO is released.
module csr_mii_bridge
    import csr_mii_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int MDC_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        cmd_err,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic        cmd_busy, cmd_rnw;
    logic [7:0]  cmd_addr;
    logic [31:0] data_word, bank_rdata;
    logic        mgmt_busy, mgmt_start, mgmt_done_rd;
    mgmt_t       start_cfg;
    logic [15:0] mgmt_wdata, mgmt_rdata;

    csr_host_port i_host (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .mgmt_busy(mgmt_busy), .bank_rdata(bank_rdata),
        .host_rdata(host_rdata), .cmd_busy(cmd_busy), .cmd_rnw(cmd_rnw),
        .cmd_addr(cmd_addr), .data_word(data_word), .cmd_err(cmd_err)
    );

    csr_reg_bank #(.NREG(NREG)) i_bank (
        .clk(clk), .rst_n(rst_n), .xfer_en(cmd_busy), .xfer_rnw(cmd_rnw),
        .xfer_addr(cmd_addr), .xfer_wdata(data_word), .mgmt_busy(mgmt_busy),
        .mgmt_done_rd(mgmt_done_rd), .mgmt_rdata(mgmt_rdata), .rdata(bank_rdata),
        .mgmt_start(mgmt_start), .start_cfg(start_cfg), .mgmt_wdata(mgmt_wdata)
    );

    mdio_master #(.MDC_HALF(MDC_HALF)) i_mdio (
        .clk(clk), .rst_n(rst_n), .start(mgmt_start), .start_cfg(start_cfg),
        .wdata(mgmt_wdata), .mdio_in(mdio_in), .busy(mgmt_busy), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .done_rd(mgmt_done_rd), .rdata(mgmt_rdata)
    );
endmodule

// File: rtl/csr_mii_bridge_chk.sv
`timescale 1ns/1ps
// Property checker for the bridge, attached by bind.
module csr_mii_bridge_chk (
    input logic clk,
    input logic rst_n,
    input logic host_wr,
    input logic cmd_busy,
    input logic mgmt_busy,
    input logic cmd_err,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe
);
    AST_CMD_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !cmd_busy); // R3
    AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && cmd_busy |=> cmd_err); // R5
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(host_wr)); // R5
    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mgmt_busy |-> !mdc && !mdio_oe); // R10
    AST_MDIO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_busy && mdc |-> $stable(mdio_out) && $stable(mdio_oe)); // R10
endmodule

bind csr_mii_bridge csr_mii_bridge_chk i_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .cmd_busy(cmd_busy),
    .mgmt_busy(mgmt_busy), .cmd_err(cmd_err), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/test_csr_mii_bridge.sv
`timescale 1ns/1ps
// Self-checking bench: table walk over the command tier, then directed frame and corner tests.
module test_csr_mii_bridge;
    localparam int MDC_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        cmd_err, mdc, mdio_out, mdio_oe, mdio_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // PHY model state
    int          rise_cnt = 99;
    logic [15:0] phy_rd = 16'h0;
    logic        cap_o [64];
    logic        cap_e [64];
    realtime     last_rise = 0;
    int          bad_period = 0;

    always #5 clk = ~clk;

    csr_mii_bridge #(.NREG(8), .MDC_HALF(MDC_HALF)) i_csr_mii_bridge (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_err(cmd_err),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    assign mdio_in = (rise_cnt >= 48 && rise_cnt < 64) ? phy_rd[63 - rise_cnt] : 1'b1;

    // Record each frame bit at MDC rising edges and measure the MDC period.
    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_o[rise_cnt] = mdio_out;
            cap_e[rise_cnt] = mdio_oe;
            if (rise_cnt > 0 && ($realtime - last_rise) != real'(2 * MDC_HALF * 10)) bad_period++;
        end
        last_rise = $realtime;
        rise_cnt++;
    end

    localparam logic [71:0] VEC [6] = '{
        {8'd0, 32'hA5A5_0001, 32'hA5A5_0001},
        {8'd3, 32'h1234_5678, 32'h1234_5678},
        {8'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {8'd9, 32'hDEAD_BEEF, 32'h0000_0000},
        {8'd7, 32'h89AB_CDEF, 32'h0000_CDEF},
        {8'd6, 32'hFFFF_FFFE, 32'h0000_FFC2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [31:0] d);
        host_sel = sel;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_cmd_idle();
        logic [31:0] v;
        host_read(1'b0, v);
        while (v[31]) begin
            @(negedge clk);
            host_read(1'b0, v);
        end
    endtask

    task automatic csr_write(input logic [7:0] idx, input logic [31:0] d);
        host_write(1'b1, d);
        host_write(1'b0, {2'b10, 22'b0, idx});
        wait_cmd_idle();
    endtask

    task automatic csr_read(input logic [7:0] idx, output logic [31:0] d);
        host_write(1'b0, {2'b11, 22'b0, idx});
        wait_cmd_idle();
        host_read(1'b1, d);
    endtask

    task automatic wait_mgmt_idle();
        logic [31:0] v;
        csr_read(8'd6, v);
        while (v[0]) csr_read(8'd6, v);
    endtask

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, (wr ? 2'b10 : 2'b00), d};
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) act=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] ef;
        int          miss;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        host_read(1'b0, v); chk("R1 command word", v, 32'h0);
        host_read(1'b1, v); chk("R1 data word", v, 32'h0);
        chk("R1 mdc/oe/err", {29'b0, mdc, mdio_oe, cmd_err}, 32'h0);

        // R2, R4, R6: table walk over the command tier
        for (int i = 0; i < 6; i++) begin
            csr_write(VEC[i][71:64], VEC[i][63:32]);
            csr_read(VEC[i][71:64], v);
            chk($sformatf("R2/R4/R6 vector %0d idx %0d", i, VEC[i][71:64]), v, VEC[i][31:0]);
        end
        csr_read(8'd0, v); chk("R4 index 0 kept", v, 32'hA5A5_0001);
        chk("R6 no frame without busy", {31'b0, mdio_oe}, 32'h0);

        // R3: busy visible for exactly one cycle after a combined write
        host_write(1'b0, {2'b11, 22'b0, 8'd3});
        host_read(1'b0, v); chk("R3 busy set", v, {2'b11, 22'b0, 8'd3});
        @(negedge clk);
        host_read(1'b0, v); chk("R3 busy cleared", v, {2'b01, 22'b0, 8'd3});
        host_read(1'b1, v); chk("R2 read into data word", v, 32'h1234_5678);

        // R5: write refused while the command tier is busy
        host_write(1'b1, 32'hCAFE_0001);
        host_write(1'b0, {2'b10, 22'b0, 8'd2});
        host_wr = 1'b1; host_sel = 1'b1; host_wdata = 32'hBAD0_BAD0;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R5 error pulse", {31'b0, cmd_err}, 32'h1);
        host_read(1'b1, v); chk("R5 data word unchanged", v, 32'hCAFE_0001);
        @(negedge clk);
        chk("R5 error one cycle", {31'b0, cmd_err}, 32'h0);
        csr_read(8'd2, v); chk("R5 register 2 written", v, 32'hCAFE_0001);

        // R7, R8: write frame to PHY 3 register 4
        csr_write(8'd7, 32'h0000_A50F);
        rise_cnt = 0; bad_period = 0;
        csr_write(8'd6, {16'b0, 5'd3, 5'd4, 4'b0, 1'b1, 1'b1});
        csr_read(8'd6, v); chk("R7 busy during frame", v, {16'b0, 5'd3, 5'd4, 4'b0, 1'b1, 1'b1});
        // R5: command to index 7 refused while a frame runs
        host_write(1'b1, 32'h0000_5555);
        host_write(1'b0, {2'b10, 22'b0, 8'd7});
        chk("R5 refused during frame", {31'b0, cmd_err}, 32'h1);
        wait_mgmt_idle();
        csr_read(8'd6, v); chk("R7 fields kept, busy clear", v, {16'b0, 5'd3, 5'd4, 4'b0, 1'b1, 1'b0});
        ef = exp_frame(1'b1, 5'd3, 5'd4, 16'hA50F);
        miss = 0;
        for (int b = 0; b < 64; b++) if (cap_o[b] !== ef[63-b] || cap_e[b] !== 1'b1) miss++;
        chk("R8 write frame bits", miss, 0);
        chk("R10 rising edges", rise_cnt, 64);
        chk("R10 MDC period", bad_period, 0);
        csr_read(8'd7, v); chk("R5 index 7 kept", v, 32'h0000_A50F);

        // R9: read frame from PHY 1 register 2
        phy_rd = 16'hC3E1;
        rise_cnt = 0; bad_period = 0;
        csr_write(8'd6, {16'b0, 5'd1, 5'd2, 4'b0, 1'b0, 1'b1});
        wait_mgmt_idle();
        ef = exp_frame(1'b0, 5'd1, 5'd2, 16'h0);
        miss = 0;
        for (int b = 0; b < 46; b++) if (cap_o[b] !== ef[63-b] || cap_e[b] !== 1'b1) miss++;
        chk("R9 read header bits", miss, 0);
        miss = 0;
        for (int b = 46; b < 64; b++) if (cap_e[b] !== 1'b0) miss++;
        chk("R9 bus released", miss, 0);
        csr_read(8'd7, v); chk("R9 read data", v, 32'h0000_C3E1);
        chk("R10 rising edges read", rise_cnt, 64);
        @(negedge clk);
        chk("R10 idle low", {30'b0, mdc, mdio_oe}, 32'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule